// File: doc/BRIEF.md
# Occupancy-Driven Room Lighting Controller

This block drives the lighting of a meeting room from three synchronous inputs: an occupancy level from a motion detector, a liveness strobe that a healthy detector raises at least once per watchdog window, and a manual request to restore the default light scene. A parameterised prescaler divides the system clock down to a one-second enable, and every timer in the block advances only on that enable.

Three second-counting timers run side by side. The longer no-motion timer restores the default scene when it completes, and the shorter one switches the lights off. The liveness watchdog raises a failure flag when the detector stays silent for a full window. While that flag is raised, the lights are never switched off automatically, because the absence of motion can no longer be trusted. Any sample with motion present restarts both no-motion timers and turns the lights on. All limits are parameters, so a simulation can use short windows.

Top module: `room_light_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, lights_o is 1, failure_o is 0 and scene_rst_o is 0.
- R2: A one-second enable is raised once every TICK_DIV clock cycles. The three timers count only on that enable and stop counting at their limit.
- R3: When the dark timer has counted DARK_SECS enables with motion_i low throughout and failure_o is 0, lights_o goes to 0 on the next clock edge.
- R4: A cycle with motion_i equal to 1 clears both no-motion timers, and lights_o is 1 from the next cycle on.
- R5: When PULSE_SECS enables pass with pulse_i low throughout, failure_o goes to 1 in the cycle the watchdog count reaches its limit.
- R6: A cycle with pulse_i equal to 1 clears the watchdog, and failure_o is 0 from the next cycle on.
- R7: While failure_o is 1, lights_o is not driven from 1 to 0.
- R8: scene_rst_o is high for exactly one cycle when the scene timer reaches SCENE_SECS, and it does not rise again from the timer until motion has restarted that timer.
- R9: Motion seen before the scene timer completes cancels the pending scene reset, and counting restarts from zero.
- R10: A rising edge on scene_req_i gives one scene_rst_o pulse in the next cycle. Holding scene_req_i high gives no further pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| motion_i | input | 1 | Occupancy level, 1 when motion is present |
| pulse_i | input | 1 | Detector liveness strobe |
| scene_req_i | input | 1 | Manual request to restore the default scene |
| lights_o | output | 1 | Lights enable |
| failure_o | output | 1 | Detector failure flag |
| scene_rst_o | output | 1 | One-cycle command to restore the default scene |

## Verification
The hardest state to reach is a failure flag that is already raised when the dark timer expires. The stimulus gets there by holding motion high while the liveness strobe is stopped, so the watchdog expires while the dark timer is held at zero. It then drops motion and waits well past the dark limit, and finally restarts the strobe. This shows that the lights stay on throughout the failure and go off on the first cycle after the flag clears. A second hard case is the scene timer stopping short of its limit: motion blips are spaced just under the scene window, with the strobe kept alive, so that the timer is cancelled again and again without firing.

// File: rtl/light_ctrl_pkg.sv
package light_ctrl_pkg;
  typedef enum logic [1:0] {
    TMR_SCENE = 2'd0,
    TMR_DARK  = 2'd1,
    TMR_LIVE  = 2'd2
  } tmr_id_e;

  localparam int unsigned NUM_TMR = 3;
endpackage

// File: rtl/sec_tick_gen.sv
module sec_tick_gen #(
  parameter int unsigned TICK_DIV = 100_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int unsigned LIMIT = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  output logic expired_o
);
  localparam int unsigned SW = $clog2(LIMIT + 1);
  localparam logic [SW-1:0] TOP = SW'(LIMIT);

  logic [SW-1:0] sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   sec_q <= '0;
    else if (clear_i)              sec_q <= '0;
    else if (tick_i && sec_q < TOP) sec_q <= sec_q + 1'b1;
  end

  assign expired_o = (sec_q == TOP);
endmodule

// File: rtl/room_light_ctrl.sv
module room_light_ctrl
  import light_ctrl_pkg::*;
#(
  parameter int unsigned TICK_DIV   = 100_000_000,
  parameter int unsigned SCENE_SECS = 300,
  parameter int unsigned DARK_SECS  = 150,
  parameter int unsigned PULSE_SECS = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic motion_i,
  input  logic pulse_i,
  input  logic scene_req_i,
  output logic lights_o,
  output logic failure_o,
  output logic scene_rst_o
);
  localparam int unsigned LIMITS [NUM_TMR] = '{SCENE_SECS, DARK_SECS, PULSE_SECS};

  logic               tick;
  logic [NUM_TMR-1:0] clr;
  logic [NUM_TMR-1:0] expired;

  sec_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  assign clr[TMR_SCENE] = motion_i;
  assign clr[TMR_DARK]  = motion_i;
  assign clr[TMR_LIVE]  = pulse_i;

  generate
    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
      idle_timer #(.LIMIT(LIMITS[g])) u_tmr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .clear_i   (clr[g]),
        .expired_o (expired[g])
      );
    end
  endgenerate

  logic lights_q, scene_exp_q, req_q, man_q;

  // failure blocks automatic switch-off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    lights_q <= 1'b1;
    else if (motion_i)                              lights_q <= 1'b1;
    else if (expired[TMR_DARK] && !expired[TMR_LIVE]) lights_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scene_exp_q <= 1'b0;
      req_q       <= 1'b0;
      man_q       <= 1'b0;
    end else begin
      scene_exp_q <= expired[TMR_SCENE];
      req_q       <= scene_req_i;
      man_q       <= scene_req_i && !req_q;
    end
  end

  assign lights_o    = lights_q;
  assign failure_o   = expired[TMR_LIVE];
  assign scene_rst_o = (expired[TMR_SCENE] && !scene_exp_q) || man_q;
endmodule

// File: rtl/light_ctrl_checker.sv
module light_ctrl_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic motion_i,
  input logic pulse_i,
  input logic lights_o,
  input logic failure_o
);
  a_r4_motion_lights_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    motion_i |=> lights_o);

  a_r6_pulse_clears_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> !failure_o);

  a_r7_no_off_in_failure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lights_o) |-> !$past(failure_o));

  a_r3_off_needs_no_motion: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lights_o) |-> !$past(motion_i));

  a_r5_fail_needs_silence: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(failure_o) |-> !$past(pulse_i));
endmodule

bind room_light_ctrl light_ctrl_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .motion_i  (motion_i),
  .pulse_i   (pulse_i),
  .lights_o  (lights_o),
  .failure_o (failure_o)
);

// File: tb/sim_room_light_ctrl.sv
`timescale 1ns/1ps
module sim_room_light_ctrl;
  localparam int DIV = 4, SL = 12, DL = 6, PL = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic motion = 1'b0, pulse = 1'b0, req = 1'b0;
  logic lights, fail, scene;
  logic pulse_en = 1'b0;

  int compared = 0, mismatched = 0, cycles = 0, scene_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  room_light_ctrl #(.TICK_DIV(DIV), .SCENE_SECS(SL), .DARK_SECS(DL), .PULSE_SECS(PL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .motion_i(motion), .pulse_i(pulse),
    .scene_req_i(req), .lights_o(lights), .failure_o(fail), .scene_rst_o(scene)
  );

  // behavioural reference model
  int p, s, d, w;
  bit m_lights, m_fail, m_scene, req_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p = 0; s = 0; d = 0; w = 0;
      m_lights = 1; m_fail = 0; m_scene = 0; req_prev = 0;
    end else begin
      bit tk;
      bit s_was;
      tk = (p == DIV - 1);
      p = tk ? 0 : p + 1;
      s_was = (s == SL);
      if (motion) m_lights = 1;
      else if (d == DL && w != PL) m_lights = 0;
      if (motion) begin s = 0; d = 0; end
      else begin
        if (tk && s < SL) s++;
        if (tk && d < DL) d++;
      end
      if (pulse) w = 0; else if (tk && w < PL) w++;
      m_fail  = (w == PL);
      m_scene = (s == SL && !s_was) || (req && !req_prev);
      req_prev = req;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 R3 R4 R7 lights", lights, m_lights);
      check("R5 R6 failure", fail, m_fail);
      check("R8 R9 R10 scene_rst", scene, m_scene);
      if (scene) scene_seen++;
    end
  end

  int pc = 0;
  always @(negedge clk) begin
    if (pulse_en) begin
      pc++;
      pulse <= (pc % 12 == 0);
    end else begin
      pulse <= 1'b0;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check("R1 reset lights", lights, 1);
    check("R1 reset failure", fail, 0);
    check("R1 reset scene", scene, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset lights", lights, 1);
    check("R1 post-reset failure", fail, 0);

    // lights off and one scene reset after quiet period
    pulse_en = 1'b1;
    motion = 1'b1; repeat (3) @(negedge clk);
    motion = 1'b0; repeat (70) @(negedge clk);
    check("R3 lights off", lights, 0);
    check("R8 one scene pulse", scene_seen, 1);
    repeat (60) @(negedge clk);
    check("R8 no repeat", scene_seen, 1);

    motion = 1'b1; @(negedge clk);
    check("R4 motion relights", lights, 1);
    motion = 1'b0;
    for (int k = 0; k < 4; k++) begin
      repeat (40) @(negedge clk);
      motion = 1'b1; @(negedge clk); motion = 1'b0;
    end
    check("R9 cancelled scene", scene_seen, 1);

    // failure before dark timer can expire
    motion = 1'b1; pulse_en = 1'b0;
    repeat (30) @(negedge clk);
    check("R5 failure raised", fail, 1);
    motion = 1'b0;
    repeat (60) @(negedge clk);
    check("R7 lights held on", lights, 1);
    pulse_en = 1'b1;
    repeat (14) @(negedge clk);
    check("R6 failure cleared", fail, 0);
    check("R3 lights off after clear", lights, 0);

    base = scene_seen;
    req = 1'b1; repeat (10) @(negedge clk);
    check("R10 single manual pulse", scene_seen - base, 1);
    req = 1'b0; repeat (2) @(negedge clk);
    req = 1'b1; repeat (3) @(negedge clk);
    req = 1'b0; @(negedge clk);
    check("R10 second rise", scene_seen - base, 2);

    finish_run();
  end
endmodule